// File: doc/BRIEF.md
# Operand Collector Pool with Rotating Dispatch

This block keeps a small pool of collector units that sit between instruction issue and the execution pipelines. A unit is claimed by an allocation that carries the instruction word, the register numbers of up to four source operands and the index of the output pipeline register the instruction is bound for. Every source slot that names a real register becomes an outstanding operand. The register file side reports each delivered operand with a strobe that names the unit and the slot.

A unit may leave the pool once nothing is outstanding and its bound output register reports empty. One or more dispatch selectors pick among such units each cycle. Each selector searches in a rotating order that starts one past the unit it granted last. A grant presents the unit, its output index and its instruction on the dispatch outputs, and the unit returns to the free pool on the next clock edge. Selectors are chained: a later selector never sees a unit, or an output register, already taken by an earlier one in the same cycle.

Top module: `opcoll_pool`

## Requirements
- R1: After reset every unit is free (`unit_free_o` all ones), no dispatch is valid, and every selector's last-granted pointer holds the highest unit index, so its first search starts at unit 0.
- R2: An allocation to a free unit makes it busy from the next cycle. Source slot k sits in `alloc_src_i[k*REG_W +: REG_W]`. A slot whose register number has its top bit set (negative) is unused. Every other slot becomes outstanding.
- R3: An allocation naming a busy unit is ignored: that unit's instruction, output binding and outstanding slots are unchanged.
- R4: A collect strobe clears the named slot of the named busy unit. A strobe for a free unit, or for a slot already clear, has no effect. A unit with any outstanding slot is never dispatched.
- R5: A unit is dispatched only while `out_empty_i` is high at the index of its bound output register.
- R6: A grant drives `disp_unit_o`, `disp_out_o` and `disp_inst_o` of that selector with the unit's index, binding and instruction in the same cycle. The unit is free from the next cycle.
- R7: Each selector searches units from (last granted + 1) modulo the unit count upward, grants the first eligible one, and records it as last granted.
- R8: When no unit is eligible a selector grants nothing and keeps its last-granted pointer.
- R9: Selector 0 has priority. A later selector excludes every unit granted by an earlier selector in that cycle and every unit bound to an output register one of them targets. No two grants in a cycle share a unit or an output index.
- R10: An allocation with all four slots unused makes the unit eligible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_unit_i | input | UW | Unit to allocate |
| alloc_src_i | input | 4*REG_W | Four source register numbers, slot k at bits k*REG_W |
| alloc_out_i | input | OW | Output register index the instruction is bound to |
| alloc_inst_i | input | INST_W | Instruction word |
| coll_valid_i | input | 1 | Operand delivered |
| coll_unit_i | input | UW | Unit receiving the operand |
| coll_op_i | input | 2 | Slot receiving the operand |
| out_empty_i | input | NUM_OUT | Per output register: empty |
| unit_free_o | output | NUM_UNITS | Per unit: free for allocation |
| disp_valid_o | output | NUM_SEL | Per selector: grant this cycle |
| disp_unit_o | output | NUM_SEL*UW | Granted unit per selector |
| disp_out_o | output | NUM_SEL*OW | Output register index per selector |
| disp_inst_o | output | NUM_SEL*INST_W | Instruction per selector |

## Verification
The assertions take for granted that the issue side only allocates units it sees free, and that it binds each instruction to an output index below NUM_OUT. They also assume collect strobes come from a source that names valid unit indices. The stimulus picks allocation targets from the units it has just seen free, except for one deliberate allocation to a busy unit, which the property on allocation effects tolerates because it only constrains allocations of free units. Output-empty flags are held steady while units are parked and are raised together, so the expected grant order follows from the rotation rule alone.

// File: rtl/opcoll_pkg.sv
package opcoll_pkg;
  localparam int unsigned SRC_SLOTS = 4;
  localparam int unsigned SLOT_W    = $clog2(SRC_SLOTS);
endpackage

// File: rtl/opcoll_unit.sv
module opcoll_unit
  import opcoll_pkg::*;
#(
  parameter int unsigned REG_W   = 8,
  parameter int unsigned INST_W  = 16,
  parameter int unsigned NUM_OUT = 2,
  parameter int unsigned OW      = 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_i,
  input  logic [SRC_SLOTS*REG_W-1:0] src_i,
  input  logic [OW-1:0]              out_idx_i,
  input  logic [INST_W-1:0]          inst_i,
  input  logic                       coll_i,
  input  logic [SLOT_W-1:0]          coll_op_i,
  input  logic                       disp_i,
  input  logic [NUM_OUT-1:0]         out_empty_i,
  output logic                       free_o,
  output logic                       ready_o,
  output logic [OW-1:0]              out_idx_o,
  output logic [INST_W-1:0]          inst_o
);
  logic                 free_q;
  logic [SRC_SLOTS-1:0] pend_q;
  logic [SRC_SLOTS-1:0] src_used;
  logic [OW-1:0]        out_q;
  logic [INST_W-1:0]    inst_q;

  // negative register number (top bit set) marks an unused slot
  always_comb begin
    for (int k = 0; k < SRC_SLOTS; k++) src_used[k] = ~src_i[k*REG_W + REG_W - 1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= 1'b1;
      pend_q <= '0;
      out_q  <= '0;
      inst_q <= '0;
    end else if (alloc_i && free_q) begin
      free_q <= 1'b0;
      pend_q <= src_used;
      out_q  <= out_idx_i;
      inst_q <= inst_i;
    end else if (disp_i) begin
      free_q <= 1'b1;
      pend_q <= '0;
      out_q  <= '0;
      inst_q <= '0;
    end else if (coll_i && !free_q) begin
      pend_q[coll_op_i] <= 1'b0;
    end
  end

  assign free_o    = free_q;
  assign ready_o   = !free_q && (pend_q == '0) && out_empty_i[out_q];
  assign out_idx_o = out_q;
  assign inst_o    = inst_q;
endmodule

// File: rtl/opcoll_rr_sel.sv
module opcoll_rr_sel #(
  parameter int unsigned N  = 4,
  parameter int unsigned UW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  output logic          gnt_valid_o,
  output logic [UW-1:0] gnt_idx_o
);
  logic [UW-1:0] last_q;

  always_comb begin
    int cand;
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    for (int off = 1; off <= int'(N); off++) begin
      cand = (int'(last_q) + off) % int'(N);
      if (!gnt_valid_o && req_i[cand]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = UW'(cand);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          last_q <= UW'(N - 1);
    else if (gnt_valid_o) last_q <= gnt_idx_o;
  end
endmodule

// File: rtl/opcoll_pool.sv
module opcoll_pool
  import opcoll_pkg::*;
#(
  parameter  int unsigned NUM_UNITS = 4,
  parameter  int unsigned NUM_SEL   = 2,
  parameter  int unsigned NUM_OUT   = 2,
  parameter  int unsigned REG_W     = 8,
  parameter  int unsigned INST_W    = 16,
  localparam int unsigned UW        = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1,
  localparam int unsigned OW        = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       alloc_valid_i,
  input  logic [UW-1:0]              alloc_unit_i,
  input  logic [SRC_SLOTS*REG_W-1:0] alloc_src_i,
  input  logic [OW-1:0]              alloc_out_i,
  input  logic [INST_W-1:0]          alloc_inst_i,
  input  logic                       coll_valid_i,
  input  logic [UW-1:0]              coll_unit_i,
  input  logic [SLOT_W-1:0]          coll_op_i,
  input  logic [NUM_OUT-1:0]         out_empty_i,
  output logic [NUM_UNITS-1:0]       unit_free_o,
  output logic [NUM_SEL-1:0]         disp_valid_o,
  output logic [NUM_SEL*UW-1:0]      disp_unit_o,
  output logic [NUM_SEL*OW-1:0]      disp_out_o,
  output logic [NUM_SEL*INST_W-1:0]  disp_inst_o
);
  logic [NUM_UNITS-1:0]              ready;
  logic [NUM_UNITS-1:0]              disp_en;
  logic [NUM_UNITS-1:0][OW-1:0]      unit_out;
  logic [NUM_UNITS-1:0][INST_W-1:0]  unit_inst;
  logic [NUM_SEL:0][NUM_UNITS-1:0]   excl;
  logic [NUM_SEL-1:0]                gnt_valid;
  logic [NUM_SEL-1:0][UW-1:0]        gnt_idx;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    opcoll_unit #(
      .REG_W(REG_W), .INST_W(INST_W), .NUM_OUT(NUM_OUT), .OW(OW)
    ) u_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .alloc_i    (alloc_valid_i && (alloc_unit_i == UW'(u))),
      .src_i      (alloc_src_i),
      .out_idx_i  (alloc_out_i),
      .inst_i     (alloc_inst_i),
      .coll_i     (coll_valid_i && (coll_unit_i == UW'(u))),
      .coll_op_i  (coll_op_i),
      .disp_i     (disp_en[u]),
      .out_empty_i(out_empty_i),
      .free_o     (unit_free_o[u]),
      .ready_o    (ready[u]),
      .out_idx_o  (unit_out[u]),
      .inst_o     (unit_inst[u])
    );
  end

  assign excl[0] = '0;

  for (genvar s = 0; s < NUM_SEL; s++) begin : g_sel
    logic [NUM_UNITS-1:0] blk;

    opcoll_rr_sel #(.N(NUM_UNITS), .UW(UW)) u_sel (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (ready & ~excl[s]),
      .gnt_valid_o(gnt_valid[s]),
      .gnt_idx_o  (gnt_idx[s])
    );

    // block the granted unit and every unit aimed at the same output register
    always_comb begin
      blk = '0;
      if (gnt_valid[s]) begin
        for (int u = 0; u < NUM_UNITS; u++)
          blk[u] = (unit_out[u] == unit_out[gnt_idx[s]]) || (gnt_idx[s] == UW'(u));
      end
    end

    assign excl[s+1]                     = excl[s] | blk;
    assign disp_valid_o[s]               = gnt_valid[s];
    assign disp_unit_o[s*UW +: UW]       = gnt_idx[s];
    assign disp_out_o[s*OW +: OW]        = unit_out[gnt_idx[s]];
    assign disp_inst_o[s*INST_W +: INST_W] = unit_inst[gnt_idx[s]];
  end

  always_comb begin
    disp_en = '0;
    for (int s = 0; s < NUM_SEL; s++)
      for (int u = 0; u < NUM_UNITS; u++)
        disp_en[u] = disp_en[u] | (gnt_valid[s] && (gnt_idx[s] == UW'(u)));
  end
endmodule

// File: rtl/opcoll_pool_chk.sv
module opcoll_pool_chk #(
  parameter int unsigned NUM_UNITS = 4,
  parameter int unsigned NUM_SEL   = 2,
  parameter int unsigned NUM_OUT   = 2,
  parameter int unsigned UW        = 2,
  parameter int unsigned OW        = 1
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  alloc_valid_i,
  input logic [UW-1:0]         alloc_unit_i,
  input logic [NUM_OUT-1:0]    out_empty_i,
  input logic [NUM_UNITS-1:0]  unit_free_o,
  input logic [NUM_SEL-1:0]    disp_valid_o,
  input logic [NUM_SEL*OW-1:0] disp_out_o,
  input logic [NUM_UNITS-1:0]  disp_en
);
  p_unique_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(disp_en) == $countones(disp_valid_o));

  p_alloc_takes_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && unit_free_o[alloc_unit_i]) |=> !unit_free_o[$past(alloc_unit_i)]);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_u
    p_grant_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_en[u] |-> !unit_free_o[u]);
    p_free_after_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_en[u] |=> unit_free_o[u]);
  end

  for (genvar a = 0; a < NUM_SEL; a++) begin : g_a
    p_out_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_valid_o[a] |-> out_empty_i[disp_out_o[a*OW +: OW]]);
    for (genvar b = a + 1; b < NUM_SEL; b++) begin : g_b
      p_distinct_out_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (disp_valid_o[a] && disp_valid_o[b]) |-> (disp_out_o[a*OW +: OW] != disp_out_o[b*OW +: OW]));
    end
  end
endmodule

bind opcoll_pool opcoll_pool_chk #(
  .NUM_UNITS(NUM_UNITS), .NUM_SEL(NUM_SEL), .NUM_OUT(NUM_OUT), .UW(UW), .OW(OW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .alloc_valid_i(alloc_valid_i),
  .alloc_unit_i (alloc_unit_i),
  .out_empty_i  (out_empty_i),
  .unit_free_o  (unit_free_o),
  .disp_valid_o (disp_valid_o),
  .disp_out_o   (disp_out_o),
  .disp_en      (disp_en)
);

// File: tb/opcoll_pool_bench.sv
module opcoll_pool_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_UNITS = 4;
  localparam int NUM_SEL   = 2;
  localparam int NUM_OUT   = 2;
  localparam int REG_W     = 8;
  localparam int INST_W    = 16;
  localparam int UW        = 2;
  localparam int OW        = 1;

  logic                   clk_i = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   alloc_valid_i = 1'b0;
  logic [UW-1:0]          alloc_unit_i = '0;
  logic [4*REG_W-1:0]     alloc_src_i = '0;
  logic [OW-1:0]          alloc_out_i = '0;
  logic [INST_W-1:0]      alloc_inst_i = '0;
  logic                   coll_valid_i = 1'b0;
  logic [UW-1:0]          coll_unit_i = '0;
  logic [1:0]             coll_op_i = '0;
  logic [NUM_OUT-1:0]     out_empty_i = '1;
  logic [NUM_UNITS-1:0]   unit_free_o;
  logic [NUM_SEL-1:0]     disp_valid_o;
  logic [NUM_SEL*UW-1:0]  disp_unit_o;
  logic [NUM_SEL*OW-1:0]  disp_out_o;
  logic [NUM_SEL*INST_W-1:0] disp_inst_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { int sel; int unit; int outi; int inst; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  opcoll_pool #(
    .NUM_UNITS(NUM_UNITS), .NUM_SEL(NUM_SEL), .NUM_OUT(NUM_OUT),
    .REG_W(REG_W), .INST_W(INST_W)
  ) u_opcoll_pool (.*);

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  function automatic logic [4*REG_W-1:0] mk_src(int s0, int s1, int s2, int s3);
    return {REG_W'(s3), REG_W'(s2), REG_W'(s1), REG_W'(s0)};
  endfunction

  task automatic do_alloc(int unit, logic [4*REG_W-1:0] src, int outi, int inst);
    alloc_valid_i = 1'b1; alloc_unit_i = UW'(unit); alloc_src_i = src;
    alloc_out_i = OW'(outi); alloc_inst_i = INST_W'(inst);
    step();
    alloc_valid_i = 1'b0;
  endtask

  task automatic do_coll(int unit, int op);
    coll_valid_i = 1'b1; coll_unit_i = UW'(unit); coll_op_i = 2'(op);
    step();
    coll_valid_i = 1'b0;
  endtask

  task automatic expect_disp(int sel, int unit, int outi, int inst, string tag);
    exp_t e;
    e.sel = sel; e.unit = unit; e.outi = outi; e.inst = inst;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  // monitor: compares each grant against the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni) begin
      for (int s = 0; s < NUM_SEL; s++) begin
        if (disp_valid_o[s]) begin
          if (exp_q.size() == 0) begin
            check(0, "R4 unexpected dispatch unit", int'(disp_unit_o[s*UW +: UW]), -1);
          end else begin
            exp_t  e;
            string t;
            int    au, ao, ai;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            au = int'(disp_unit_o[s*UW +: UW]);
            ao = int'(disp_out_o[s*OW +: OW]);
            ai = int'(disp_inst_o[s*INST_W +: INST_W]);
            check(e.sel == s, {t, " selector"}, s, e.sel);
            check(e.unit == au && e.outi == ao && e.inst == ai, {t, " unit/out/inst"},
                  (au << 20) | (ao << 16) | ai, (e.unit << 20) | (e.outi << 16) | e.inst);
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check(unit_free_o == 4'b1111, "R1 free after reset", int'(unit_free_o), 15);
    check(disp_valid_o == '0, "R1 no dispatch in reset", int'(disp_valid_o), 0);
    #1 rst_ni = 1'b1;
    step();
    @(negedge clk_i);
    check(unit_free_o == 4'b1111, "R1 free after release", int'(unit_free_o), 15);
    step();

    // R2/R4/R6: slots 0 and 2 used, collected one by one, with no-effect strobes
    do_alloc(0, mk_src(5, -1, 7, -3), 0, 16'hA1);
    check(unit_free_o == 4'b1110, "R2 unit 0 busy", int'(unit_free_o), 14);
    do_coll(0, 0);
    do_coll(0, 0);            // R4 already clear
    do_coll(1, 2);            // R4 free unit
    do_coll(0, 1);            // R4 unused slot
    step();
    check(unit_free_o == 4'b1110, "R4 still waiting on slot 2", int'(unit_free_o), 14);
    expect_disp(0, 0, 0, 16'hA1, "R6");
    do_coll(0, 2);
    step(); step();
    check(exp_q.size() == 0, "R4 dispatch after last operand", exp_q.size(), 0);
    check(unit_free_o == 4'b1111, "R6 unit freed", int'(unit_free_o), 15);

    // R3/R5/R10: park unit 1 behind a full output, then retarget attempt
    out_empty_i = 2'b01;
    do_alloc(1, mk_src(-1, -1, -1, -1), 1, 16'hB2);
    step(); step();
    check(unit_free_o == 4'b1101, "R5 parked while output full", int'(unit_free_o), 13);
    do_alloc(1, mk_src(3, -1, -1, -1), 0, 16'hC3);
    step();
    check(unit_free_o == 4'b1101, "R3 busy unit kept", int'(unit_free_o), 13);
    expect_disp(0, 1, 1, 16'hB2, "R3 R10");
    out_empty_i = 2'b11;
    step(); step();
    check(exp_q.size() == 0, "R10 parked unit dispatched", exp_q.size(), 0);
    check(unit_free_o == 4'b1111, "R6 unit 1 freed", int'(unit_free_o), 15);
    repeat (3) step();        // R8 idle: pointers held

    // R7: four units on one output, one grant per cycle in rotating order
    out_empty_i = 2'b00;
    for (int u = 0; u < 4; u++) do_alloc(u, mk_src(-1, -1, -1, -1), 0, 16'hD0 + u);
    check(unit_free_o == 4'b0000, "R5 all parked", int'(unit_free_o), 0);
    expect_disp(0, 2, 0, 16'hD2, "R7 R8");
    expect_disp(0, 3, 0, 16'hD3, "R7");
    expect_disp(0, 0, 0, 16'hD0, "R7");
    expect_disp(0, 1, 0, 16'hD1, "R7");
    out_empty_i = 2'b01;
    repeat (6) step();
    check(exp_q.size() == 0, "R7 rotation drained", exp_q.size(), 0);
    check(unit_free_o == 4'b1111, "R6 all freed", int'(unit_free_o), 15);

    // R9: two selectors, two outputs
    out_empty_i = 2'b00;
    do_alloc(0, mk_src(-1, -1, -1, -1), 0, 16'hE0);
    do_alloc(1, mk_src(-1, -1, -1, -1), 1, 16'hE1);
    do_alloc(2, mk_src(-1, -1, -1, -1), 0, 16'hE2);
    do_alloc(3, mk_src(-1, -1, -1, -1), 1, 16'hE3);
    expect_disp(0, 2, 0, 16'hE2, "R9");
    expect_disp(1, 1, 1, 16'hE1, "R9");
    expect_disp(0, 3, 1, 16'hE3, "R9");
    expect_disp(1, 0, 0, 16'hE0, "R9");
    out_empty_i = 2'b11;
    repeat (4) step();
    check(exp_q.size() == 0, "R9 paired grants drained", exp_q.size(), 0);
    check(unit_free_o == 4'b1111, "R9 all freed", int'(unit_free_o), 15);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule